// File: doc/BRIEF.md
# Pointer-Addressed RAM Access Port

This block lets a host reach a 2048-byte internal RAM without putting RAM addresses on the host bus. The host sees four byte-wide registers, chosen by a 2-bit select. One register holds the low byte of an 11-bit address pointer. A control register holds the top pointer bits, a read-mode bit and an auto-increment bit. A data register is the only path to the RAM contents.

Loading the low pointer byte while read mode is set fetches the addressed byte into the data register in the background. The host then reads it with no wait state. Writing the data register keeps the byte there and commits it to the RAM location at the pointer on the next cycle. With auto-increment set, every data access moves the pointer on by one, and a data read also fetches the following byte. This supports streaming a buffer in or out. With auto-increment clear, the pointer stays where it is, which gives random access.

The host strobes `hsel` for one cycle per access and leaves at least two idle cycles between accesses. That gap is the time the background fetch or commit needs, so no ready signal exists.

Top module: `ptr_ram_port`

## Requirements
- R1: After reset, the pointer is 0, auto-increment and read mode are clear, and the data register holds 0.
- R2: Register select 0 is the data register and select 1 is the pointer low byte (pointer bits 7:0). Select 2 is the control register: bit 7 is auto-increment, bit 6 is read mode, bits 2:0 are pointer bits 10:8, and bits 5:3 read as 0. Select 3 reads as 0, and a write to it changes nothing.
- R3: A write to the pointer low byte while read mode is set loads the RAM byte at the new pointer into the data register. The host can read that byte from the third cycle after the write strobe.
- R4: A write to the control register starts no RAM access and leaves the data register unchanged.
- R5: With auto-increment clear, a data read returns the same byte every time, leaves the pointer unchanged and starts no RAM access.
- R6: With auto-increment set, a data read returns the current byte, advances the pointer by one and fetches the byte at the new pointer into the data register.
- R7: A data write places the byte in the data register and writes it into the RAM at the pointer on the following cycle. If auto-increment is set, the pointer then advances by one.
- R8: Pointer increments wrap from address 2047 to address 0.
- R9: A write to the pointer low byte while read mode is clear sets the pointer but leaves the data register unchanged.
- R10: Every access takes one strobe cycle with no wait state. Read data is valid in the strobe cycle itself. Consecutive strobes are separated by at least two idle cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hsel | input | 1 | Access strobe, one cycle per access |
| hwr | input | 1 | 1 = write access, 0 = read access |
| haddr | input | 2 | Register select |
| hwdata | input | 8 | Host write byte |
| hrdata | output | 8 | Selected register contents, combinational from `haddr` |

## Verification
The hardest case to reach is an auto-increment read stream that crosses address 2047. It needs a defined RAM byte at both the top and the bottom of the address space. It also needs the pointer to be placed close to the top through the control and low-byte registers.

The bench first fills the whole RAM through the data register with auto-increment set. That same fill walks the pointer through the wrap, which is checked by reading the pointer back. The bench then parks the pointer at 2045 and streams reads across the boundary. A behavioural model is compared with the settled register contents on every clock.

// File: rtl/ptr_ram_pkg.sv
`timescale 1ns/1ps
package ptr_ram_pkg;
    typedef enum logic [1:0] {
        SEL_DATA = 2'd0,
        SEL_PLO  = 2'd1,
        SEL_CTRL = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    localparam int CTRL_AUTO_BIT   = 7;
    localparam int CTRL_RDMODE_BIT = 6;
endpackage

// File: rtl/ptr_ram_mem.sv
`timescale 1ns/1ps
module ptr_ram_mem #(
    parameter int AW = 11,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          en,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (en) begin
            if (we) mem[addr] <= wdata;
            else    rdata     <= mem[addr];
        end
    end
endmodule

// File: rtl/ptr_ram_ctrl.sv
`timescale 1ns/1ps
module ptr_ram_ctrl
    import ptr_ram_pkg::*;
#(
    parameter int AW = 11,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hsel,
    input  logic          hwr,
    input  logic [1:0]    haddr,
    input  logic [DW-1:0] hwdata,
    output logic [DW-1:0] hrdata,
    output logic          ram_en,
    output logic          ram_we,
    output logic [AW-1:0] ram_addr,
    output logic [DW-1:0] ram_wdata,
    input  logic [DW-1:0] ram_rdata,
    output logic [AW-1:0] ptr_o,
    output logic          auto_o,
    output logic          rdmode_o
);
    localparam int HW = AW - DW;

    typedef struct packed {
        logic [AW-1:0] ptr;
        logic          auto_inc;
        logic          rd_mode;
        logic [DW-1:0] data;
        logic          fetch;   // issue RAM read this cycle
        logic          land;    // RAM read data arrives this cycle
        logic          commit;  // issue RAM write this cycle
    } st_t;

    st_t q, d;
    logic [DW-1:0] ctrl_view;

    always_comb begin
        d        = q;
        d.land   = q.fetch;
        d.fetch  = 1'b0;
        d.commit = 1'b0;

        if (q.land) d.data = ram_rdata;
        if (q.commit && q.auto_inc) d.ptr = q.ptr + AW'(1);

        if (hsel) begin
            if (hwr) begin
                unique case (reg_sel_e'(haddr))
                    SEL_DATA: begin
                        d.data   = hwdata;
                        d.commit = 1'b1;
                    end
                    SEL_PLO: begin
                        d.ptr[DW-1:0] = hwdata;
                        d.fetch       = q.rd_mode;
                    end
                    SEL_CTRL: begin
                        d.ptr[AW-1:DW] = hwdata[HW-1:0];
                        d.auto_inc     = hwdata[CTRL_AUTO_BIT];
                        d.rd_mode      = hwdata[CTRL_RDMODE_BIT];
                    end
                    default: ;
                endcase
            end else if (reg_sel_e'(haddr) == SEL_DATA && q.auto_inc) begin
                d.ptr   = q.ptr + AW'(1);
                d.fetch = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        ctrl_view                  = '0;
        ctrl_view[HW-1:0]          = q.ptr[AW-1:DW];
        ctrl_view[CTRL_AUTO_BIT]   = q.auto_inc;
        ctrl_view[CTRL_RDMODE_BIT] = q.rd_mode;
        unique case (reg_sel_e'(haddr))
            SEL_DATA: hrdata = q.data;
            SEL_PLO:  hrdata = q.ptr[DW-1:0];
            SEL_CTRL: hrdata = ctrl_view;
            default:  hrdata = '0;
        endcase
    end

    assign ram_en    = q.fetch | q.commit;
    assign ram_we    = q.commit;
    assign ram_addr  = q.ptr;
    assign ram_wdata = q.data;
    assign ptr_o     = q.ptr;
    assign auto_o    = q.auto_inc;
    assign rdmode_o  = q.rd_mode;
endmodule

// File: rtl/ptr_ram_port.sv
`timescale 1ns/1ps
module ptr_ram_port #(
    parameter int AW = 11,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hsel,
    input  logic          hwr,
    input  logic [1:0]    haddr,
    input  logic [DW-1:0] hwdata,
    output logic [DW-1:0] hrdata
);
    logic          ram_en;
    logic          ram_we;
    logic [AW-1:0] ram_addr;
    logic [DW-1:0] ram_wdata;
    logic [DW-1:0] ram_rdata;
    logic [AW-1:0] ptr_cur;
    logic          auto_cur;
    logic          rdmode_cur;

    ptr_ram_ctrl #(.AW(AW), .DW(DW)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .hsel      (hsel),
        .hwr       (hwr),
        .haddr     (haddr),
        .hwdata    (hwdata),
        .hrdata    (hrdata),
        .ram_en    (ram_en),
        .ram_we    (ram_we),
        .ram_addr  (ram_addr),
        .ram_wdata (ram_wdata),
        .ram_rdata (ram_rdata),
        .ptr_o     (ptr_cur),
        .auto_o    (auto_cur),
        .rdmode_o  (rdmode_cur)
    );

    ptr_ram_mem #(.AW(AW), .DW(DW)) u_mem (
        .clk   (clk),
        .en    (ram_en),
        .we    (ram_we),
        .addr  (ram_addr),
        .wdata (ram_wdata),
        .rdata (ram_rdata)
    );
endmodule

// File: rtl/ptr_ram_port_chk.sv
`timescale 1ns/1ps
module ptr_ram_port_chk #(
    parameter int AW = 11,
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          hsel,
    input logic          hwr,
    input logic [1:0]    haddr,
    input logic [DW-1:0] hwdata,
    input logic [DW-1:0] hrdata,
    input logic          ram_en,
    input logic          ram_we,
    input logic [AW-1:0] ram_addr,
    input logic [DW-1:0] ram_wdata,
    input logic [AW-1:0] ptr_cur,
    input logic          auto_cur,
    input logic          rdmode_cur
);
    // R10
    strobe_gap1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hsel |=> !hsel);

    // R10
    strobe_gap2_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hsel |=> ##1 !hsel);

    // R3
    plo_prefetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hsel && hwr && haddr == 2'd1 && rdmode_cur)
        |=> (ram_en && !ram_we && ram_addr[DW-1:0] == $past(hwdata)));

    // R9
    plo_nofetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hsel && hwr && haddr == 2'd1 && !rdmode_cur) |=> !ram_en);

    // R4
    ctrl_nofetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hsel && hwr && haddr == 2'd2) |=> !ram_en);

    // R7
    data_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hsel && hwr && haddr == 2'd0)
        |=> (ram_en && ram_we && ram_wdata == $past(hwdata)
             && ram_addr == $past(ptr_cur)));

    // R5
    fixed_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hsel && !hwr && haddr == 2'd0 && !auto_cur)
        |=> (!ram_en && $stable(ptr_cur)));

    // R6, R8
    auto_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hsel && !hwr && haddr == 2'd0 && auto_cur)
        |=> (ram_en && !ram_we && ram_addr == AW'($past(ptr_cur) + AW'(1))));

    // R2
    sel3_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hsel && hwr && haddr == 2'd3)
        |=> ($stable(ptr_cur) && $stable(auto_cur) && $stable(rdmode_cur)));

    // R2
    sel3_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (haddr == 2'd3) |-> (hrdata == '0));
endmodule

bind ptr_ram_port ptr_ram_port_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .hsel       (hsel),
    .hwr        (hwr),
    .haddr      (haddr),
    .hwdata     (hwdata),
    .hrdata     (hrdata),
    .ram_en     (ram_en),
    .ram_we     (ram_we),
    .ram_addr   (ram_addr),
    .ram_wdata  (ram_wdata),
    .ptr_cur    (ptr_cur),
    .auto_cur   (auto_cur),
    .rdmode_cur (rdmode_cur)
);

// File: tb/ptr_ram_port_tb.sv
`timescale 1ns/1ps
module ptr_ram_port_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hsel = 1'b0;
    logic       hwr = 1'b0;
    logic [1:0] haddr = 2'd0;
    logic [7:0] hwdata = 8'd0;
    logic [7:0] hrdata;

    ptr_ram_port u_dut (
        .clk(clk), .rst_n(rst_n), .hsel(hsel), .hwr(hwr),
        .haddr(haddr), .hwdata(hwdata), .hrdata(hrdata)
    );

    always #2.5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // behavioural reference model
    logic [7:0] m_mem [int];
    int         m_ptr = 0;
    bit         m_auto = 1'b0;
    bit         m_rd = 1'b0;
    logic [7:0] m_data = 8'h00;
    int         idle = 0;
    bit         live = 1'b0;

    function automatic logic [7:0] m_reg(input logic [1:0] a);
        case (a)
            2'd0:    return m_data;
            2'd1:    return m_ptr[7:0];
            2'd2:    return {m_auto, m_rd, 3'b000, m_ptr[10:8]};
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [7:0] m_at(input int a);
        if (m_mem.exists(a)) return m_mem[a];
        return 8'hxx;
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    always @(posedge clk) if (idle < 1000) idle++;

    // every-clock comparison of the settled register view
    always @(negedge clk) begin
        #1;
        if (live && !done && idle >= 2) chk("R2 monitor", hrdata, m_reg(haddr));
    end

    task automatic access(input bit wr, input logic [1:0] a, input logic [7:0] dv,
                          input string req);
        @(negedge clk);
        hsel = 1'b1; hwr = wr; haddr = a; hwdata = dv; idle = -1;
        #1;
        if (!wr) chk(req, hrdata, m_reg(a));
        if (wr) begin
            case (a)
                2'd0: begin
                    m_data = dv; m_mem[m_ptr] = dv;
                    if (m_auto) m_ptr = (m_ptr + 1) % 2048;
                end
                2'd1: begin
                    m_ptr = (m_ptr & 'h700) | int'(dv);
                    if (m_rd) m_data = m_at(m_ptr);
                end
                2'd2: begin
                    m_ptr  = (m_ptr & 'hFF) | (int'(dv[2:0]) << 8);
                    m_auto = dv[7];
                    m_rd   = dv[6];
                end
                default: ;
            endcase
        end else if (a == 2'd0 && m_auto) begin
            m_ptr  = (m_ptr + 1) % 2048;
            m_data = m_at(m_ptr);
        end
        @(negedge clk);
        hsel = 1'b0; hwr = 1'b0;
        @(negedge clk);
    endtask

    task automatic wait_idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run;
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        live  = 1'b1;

        // R1 reset state
        access(1'b0, 2'd1, 8'h00, "R1 ptr low");
        access(1'b0, 2'd2, 8'h00, "R1 ctrl");
        access(1'b0, 2'd0, 8'h00, "R1 data");
        access(1'b0, 2'd3, 8'h00, "R2 sel3 zero");

        // R9 pointer load in write mode keeps data register
        access(1'b1, 2'd1, 8'h55, "R9");
        wait_idle(3);
        access(1'b0, 2'd0, 8'h00, "R9 data kept");
        access(1'b0, 2'd1, 8'h00, "R9 ptr low set");

        // fill RAM with auto-increment writes (R7), pointer wraps (R8)
        access(1'b1, 2'd2, 8'h80, "R2");
        access(1'b1, 2'd1, 8'h00, "R7");
        for (int i = 0; i < 2048; i++) access(1'b1, 2'd0, 8'((i * 7 + 3) & 'hFF), "R7");
        access(1'b0, 2'd1, 8'h00, "R8 wrap ptr low");
        access(1'b0, 2'd2, 8'h00, "R8 wrap ctrl");

        // R4 control write does not touch data register
        access(1'b1, 2'd2, 8'h45, "R4");
        wait_idle(3);
        access(1'b0, 2'd0, 8'h00, "R4 data kept");
        access(1'b0, 2'd2, 8'h00, "R2 ctrl view");

        // R3 prefetch on low byte, read at minimum spacing (R10)
        access(1'b1, 2'd1, 8'h10, "R3");
        access(1'b0, 2'd0, 8'h00, "R3 R10 prefetch");
        access(1'b0, 2'd0, 8'h00, "R5 repeat");
        access(1'b0, 2'd0, 8'h00, "R5 repeat");
        access(1'b0, 2'd1, 8'h00, "R5 ptr fixed");

        // R6 auto-increment stream crossing the top (R8)
        access(1'b1, 2'd2, 8'hC7, "R6");
        access(1'b1, 2'd1, 8'hFD, "R6");
        for (int i = 0; i < 5; i++) access(1'b0, 2'd0, 8'h00, "R6 R8 stream");
        access(1'b0, 2'd1, 8'h00, "R8 ptr low");
        access(1'b0, 2'd2, 8'h00, "R8 ctrl");
        wait_idle(4);

        // R7 random writes, read back
        access(1'b1, 2'd2, 8'h82, "R7");
        access(1'b1, 2'd1, 8'h20, "R7");
        access(1'b1, 2'd0, 8'hA1, "R7");
        access(1'b1, 2'd0, 8'hB2, "R7");
        access(1'b1, 2'd0, 8'hC3, "R7");
        access(1'b1, 2'd2, 8'h02, "R7");
        access(1'b0, 2'd0, 8'h00, "R7 data reg");
        access(1'b0, 2'd1, 8'h00, "R7 ptr advanced");
        access(1'b1, 2'd2, 8'h42, "R7");
        access(1'b1, 2'd1, 8'h20, "R7");
        access(1'b0, 2'd0, 8'h00, "R7 ram byte0");
        access(1'b1, 2'd1, 8'h22, "R7");
        access(1'b0, 2'd0, 8'h00, "R7 ram byte2");

        // R2 select 3 write ignored
        access(1'b1, 2'd3, 8'hFF, "R2");
        access(1'b0, 2'd2, 8'h00, "R2 sel3 ctrl kept");
        access(1'b0, 2'd1, 8'h00, "R2 sel3 ptr kept");
        access(1'b0, 2'd3, 8'h00, "R2 sel3 zero");
        access(1'b0, 2'd0, 8'h00, "R2 sel3 data kept");
        wait_idle(4);

        finish_run();
    end
endmodule